// File: doc/BRIEF.md
# PCI Host Bridge Register Window

This block is the CPU-facing register file of a bus host bridge. A requester issues 32-bit reads and writes by byte offset. The low part of the offset space is a window onto the bridge's own 256-byte configuration header, which is held in internal storage. A small group of registers sits above that window:

- a configuration address register;
- a memory base register;
- an I/O base register that places a 256 KB I/O window in system memory;
- a data port.

Every access to the data port becomes one configuration cycle on a downstream request/acknowledge interface. The target of that cycle is the current contents of the configuration address register.

The block also routes device interrupts. A device's slot number selects one of the interrupt output lines directly.

Handshake: the requester raises `cpu_req` and holds it, together with the command, until it sees `cpu_ready` high for one cycle.

- For any local offset, `cpu_ready` rises in the cycle after the request is seen.
- For the data port, `cpu_ready` stays low until the downstream side returns `cfg_ack`.

Top module: `pcib_regwin`

## Requirements
- R1: Offsets 0x000 to 0x0FC address the 64 words of the bridge's own configuration header. A full write stores all 32 bits of the word, and a later read returns them. Header byte N maps to bits 8*(N mod 4)+7:8*(N mod 4) of the word at offset N rounded down to a multiple of 4.
- R2: After reset, header word 0 reads {DEVICE_ID, VENDOR_ID}, and header word 1 reads 0x02900080. That value is the command half with bit 7 (wait cycles) set, and the status half with bits 4 (capability list), 7 (fast back-to-back) and 9 (medium device-select timing) set. All other header words read 0.
- R3: Offset 0x1C0 is the configuration address register. It resets to 0, stores all 32 written bits and reads them back.
- R4: Offset 0x1C4 is the memory base register. It resets to 0 and stores the written value ANDed with 0xFF000001.
- R5: Offset 0x1C8 is the I/O base register. It resets to 0xFE240000, and output `io_base` always equals it. A write stores the value ANDed with 0xFFFC0001, but only when bits 31:18 of the written value differ from the stored bits 31:18; otherwise the register keeps its old value, including bit 0.
- R6: Each relocation of the I/O window raises `io_moved` for exactly one cycle. During that cycle `io_base` already shows the new base. Writes that do not relocate the window raise no pulse.
- R7: A full write to offset 0x220 raises `cfg_req` with `cfg_we`=1. It drives `cfg_addr` with the configuration address register and `cfg_wdata` with the written data, and holds all of these until `cfg_ack`. `cpu_ready` stays low until the acknowledge arrives, then pulses one cycle later.
- R8: A full read of offset 0x220 raises `cfg_req` with `cfg_we`=0. It returns the `cfg_rdata` value present with `cfg_ack` on `cpu_rdata` while `cpu_ready` is high.
- R9: Accesses to any other offset, unaligned offsets, and accesses with `cpu_be` other than 4'b1111 change no state and start no downstream cycle. They complete with read data 0.
- R10: Interrupt line k (k from 0 to IRQ_LINES-1) is high exactly when `irq_assert` is high and `irq_devfn[7:3]` equals k. A slot number of IRQ_LINES or more drives no line.
- R11: An access to any offset other than a full data-port access completes with `cpu_ready` high in the cycle after the request is accepted. `cpu_ready` is always a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 10 | Byte offset into the register window |
| cpu_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cfg_req | output | 1 | Downstream configuration cycle request |
| cfg_we | output | 1 | Downstream cycle direction, 1 = write |
| cfg_addr | output | 32 | Downstream configuration address |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Downstream completion |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ack |
| io_base | output | 32 | Current I/O base register |
| io_moved | output | 1 | One-cycle pulse on I/O window relocation |
| irq_devfn | input | 8 | Device/function number of the interrupting device |
| irq_assert | input | 1 | Interrupt level from that device |
| irq_lines | output | 4 | Routed interrupt outputs |

## Verification
The embedded assertions check, on every cycle:
- `io_base` never changes without an `io_moved` pulse;
- the pulse lasts one cycle;
- a pending `cfg_req` holds its address, data and direction until acknowledged;
- `cpu_ready` is a single-cycle pulse that never overlaps an open downstream request;
- interrupt lines stay at most one-hot and silent for out-of-range slots.

Only the bench scenarios can show:
- the reset contents of the header and base registers;
- the write masks;
- the rule that a same-window I/O base write leaves even bit 0 untouched;
- the data returned through the data port;
- the fact that ignored offsets and partial byte enables leave the state unchanged.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int BEW = DW / 8;

    localparam logic [AW-1:0] OFF_HDR_LAST = 10'h0FC;
    localparam logic [AW-1:0] OFF_CADDR    = 10'h1C0;
    localparam logic [AW-1:0] OFF_MBASE    = 10'h1C4;
    localparam logic [AW-1:0] OFF_IOBASE   = 10'h1C8;
    localparam logic [AW-1:0] OFF_DPORT    = 10'h220;

    localparam int HDR_WORDS = int'(OFF_HDR_LAST) / BEW + 1;
    localparam int HDR_IW    = $clog2(HDR_WORDS);

    localparam logic [DW-1:0] MBASE_MASK   = 32'hFF00_0001;
    localparam logic [DW-1:0] IOBASE_MASK  = 32'hFFFC_0001;
    localparam logic [DW-1:0] IOBASE_RESET = 32'hFE24_0000;
    localparam int            IOWIN_LSB    = 18;

    localparam logic [15:0] CMD_RESET  = 16'h0080;
    localparam logic [15:0] STAT_RESET = 16'h0290;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_HDR, SEL_CADDR, SEL_MBASE, SEL_IOBASE, SEL_DPORT
    } sel_e;

    typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_DONE} st_e;

    typedef struct packed {
        logic          we;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } cfg_cmd_t;

    function automatic sel_e decode_sel(input logic [AW-1:0] addr,
                                        input logic [BEW-1:0] be);
        if (be != {BEW{1'b1}} || addr[1:0] != 2'b00) return SEL_NONE;
        if (addr <= OFF_HDR_LAST) return SEL_HDR;
        case (addr)
            OFF_CADDR:  return SEL_CADDR;
            OFF_MBASE:  return SEL_MBASE;
            OFF_IOBASE: return SEL_IOBASE;
            OFF_DPORT:  return SEL_DPORT;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pcib_cfg_hdr.sv
module pcib_cfg_hdr
    import pcib_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB0,
    parameter logic [15:0] DEVICE_ID = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [HDR_IW-1:0] idx,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);
    logic [DW-1:0] words [HDR_WORDS];

    function automatic logic [DW-1:0] reset_word(input int i);
        case (i)
            0:       return {DEVICE_ID, VENDOR_ID};
            1:       return {STAT_RESET, CMD_RESET};
            default: return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HDR_WORDS; i++) words[i] <= reset_word(i);
        end else if (wr_en) begin
            words[idx] <= wdata;
        end
    end

    assign rdata = words[idx];
endmodule

// File: rtl/pcib_base_regs.sv
module pcib_base_regs
    import pcib_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_caddr,
    input  logic          wr_mbase,
    input  logic          wr_iobase,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] caddr,
    output logic [DW-1:0] mbase,
    output logic [DW-1:0] iobase,
    output logic          moved
);
    logic relocate;
    assign relocate = wr_iobase && (wdata[DW-1:IOWIN_LSB] != iobase[DW-1:IOWIN_LSB]);

    always_ff @(posedge clk) begin
        if (rst) begin
            caddr  <= '0;
            mbase  <= '0;
            iobase <= IOBASE_RESET;
            moved  <= 1'b0;
        end else begin
            if (wr_caddr) caddr <= wdata;
            if (wr_mbase) mbase <= wdata & MBASE_MASK;
            if (relocate) iobase <= wdata & IOBASE_MASK;
            moved <= relocate;
        end
    end

    a_r6_base_change_pulses: assert property (@(posedge clk) disable iff (rst)
        !$stable(iobase) |-> moved);
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (rst)
        moved |=> !moved);
endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
    parameter int IRQ_LINES = 4
) (
    input  logic [7:0]           irq_devfn,
    input  logic                 irq_assert,
    output logic [IRQ_LINES-1:0] irq_lines
);
    localparam int SLOT_W = 5;
    logic [SLOT_W-1:0] slot;
    assign slot = irq_devfn[7:3];

    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
        assign irq_lines[g] = irq_assert && (slot == SLOT_W'(g));
    end

    always_comb begin
        a_r10_onehot: assert ($onehot0(irq_lines));
        a_r10_out_of_range: assert (!(int'(slot) >= IRQ_LINES && irq_lines != '0));
    end
endmodule

// File: rtl/pcib_regwin.sv
module pcib_regwin
    import pcib_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB0,
    parameter logic [15:0] DEVICE_ID = 16'h0001,
    parameter int          IRQ_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [AW-1:0]        cpu_addr,
    input  logic [BEW-1:0]       cpu_be,
    input  logic [DW-1:0]        cpu_wdata,
    output logic                 cpu_ready,
    output logic [DW-1:0]        cpu_rdata,
    output logic                 cfg_req,
    output logic                 cfg_we,
    output logic [DW-1:0]        cfg_addr,
    output logic [DW-1:0]        cfg_wdata,
    input  logic                 cfg_ack,
    input  logic [DW-1:0]        cfg_rdata,
    output logic [DW-1:0]        io_base,
    output logic                 io_moved,
    input  logic [7:0]           irq_devfn,
    input  logic                 irq_assert,
    output logic [IRQ_LINES-1:0] irq_lines
);
    st_e           st;
    sel_e          sel;
    cfg_cmd_t      cmd;
    logic          wr_hit;
    logic [DW-1:0] hdr_rd, caddr, mbase, local_rd;

    assign sel    = decode_sel(cpu_addr, cpu_be);
    assign wr_hit = (st == ST_IDLE) && cpu_req && cpu_we;

    pcib_cfg_hdr #(.VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)) u_hdr (
        .clk(clk), .rst(rst),
        .wr_en(wr_hit && sel == SEL_HDR),
        .idx(cpu_addr[HDR_IW+1:2]),
        .wdata(cpu_wdata),
        .rdata(hdr_rd)
    );

    pcib_base_regs u_base (
        .clk(clk), .rst(rst),
        .wr_caddr(wr_hit && sel == SEL_CADDR),
        .wr_mbase(wr_hit && sel == SEL_MBASE),
        .wr_iobase(wr_hit && sel == SEL_IOBASE),
        .wdata(cpu_wdata),
        .caddr(caddr), .mbase(mbase), .iobase(io_base),
        .moved(io_moved)
    );

    pcib_irq_route #(.IRQ_LINES(IRQ_LINES)) u_irq (
        .irq_devfn(irq_devfn), .irq_assert(irq_assert), .irq_lines(irq_lines)
    );

    always_comb begin
        case (sel)
            SEL_HDR:    local_rd = hdr_rd;
            SEL_CADDR:  local_rd = caddr;
            SEL_MBASE:  local_rd = mbase;
            SEL_IOBASE: local_rd = io_base;
            default:    local_rd = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cpu_ready <= 1'b0;
            cpu_rdata <= '0;
            cfg_req   <= 1'b0;
            cmd       <= '0;
        end else begin
            cpu_ready <= 1'b0;
            case (st)
                ST_IDLE: if (cpu_req) begin
                    if (sel == SEL_DPORT) begin
                        cfg_req <= 1'b1;
                        cmd     <= '{we: cpu_we, addr: caddr, data: cpu_wdata};
                        st      <= ST_CFG;
                    end else begin
                        cpu_ready <= 1'b1;
                        cpu_rdata <= cpu_we ? '0 : local_rd;
                        st        <= ST_DONE;
                    end
                end
                ST_CFG: if (cfg_ack) begin
                    cfg_req   <= 1'b0;
                    cpu_ready <= 1'b1;
                    cpu_rdata <= cmd.we ? '0 : cfg_rdata;
                    st        <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cfg_we    = cmd.we;
    assign cfg_addr  = cmd.addr;
    assign cfg_wdata = cmd.data;

    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_we));
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);
    a_r7_no_ready_while_pending: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> !cpu_ready);
endmodule

// File: tb/sim_pcib_regwin.sv
module sim_pcib_regwin;
    localparam int ACK_DELAY = 3;
    localparam logic [15:0] VID = 16'h1AB0;
    localparam logic [15:0] DID = 16'h0001;

    logic        clk = 0, rst = 1;
    logic        cpu_req = 0, cpu_we = 0;
    logic [9:0]  cpu_addr = '0;
    logic [3:0]  cpu_be = 4'hF;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        cfg_req, cfg_we, cfg_ack = 0;
    logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = '0;
    logic [31:0] io_base;
    logic        io_moved;
    logic [7:0]  irq_devfn = '0;
    logic        irq_assert = 0;
    logic [3:0]  irq_lines;

    int errors = 0, checks = 0;
    int moved_cnt = 0, cfg_cnt = 0, cycles;
    logic        mon_read = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        last_we;
    logic [31:0] last_addr, last_data;
    int          dcnt = 0;

    always #2.5 clk = ~clk;

    pcib_regwin #(.VENDOR_ID(VID), .DEVICE_ID(DID), .IRQ_LINES(4)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected read data as each read completes
    always @(negedge clk) begin
        if (io_moved) moved_cnt++;
        if (cpu_ready && mon_read) begin
            if (exp_q.size() == 0) check("scoreboard", 32'hBAD, 32'h0);
            else check(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
        end
    end

    // downstream responder
    always @(negedge clk) begin
        if (cfg_ack) begin
            cfg_ack <= 0;
            dcnt = 0;
        end else if (cfg_req) begin
            if (dcnt == ACK_DELAY) begin
                cfg_ack   <= 1;
                cfg_rdata <= cfg_addr ^ 32'h5A5A_0000;
                last_we = cfg_we; last_addr = cfg_addr; last_data = cfg_wdata;
                cfg_cnt++;
            end else dcnt++;
        end
    end

    task automatic access(input logic we, input logic [9:0] a, input logic [31:0] d,
                          input logic [3:0] be);
        @(negedge clk);
        mon_read  = !we;
        cpu_req   = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        cycles = 0;
        do begin @(negedge clk); cycles++; end while (!cpu_ready && cycles < 100);
        cpu_req = 0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        access(1, a, d, 4'hF);
    endtask

    task automatic rd(input string req, input logic [9:0] a, input logic [31:0] exp);
        exp_q.push_back(exp); tag_q.push_back(req);
        access(0, a, 32'h0, 4'hF);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        // R2 reset state
        check("R5 reset io_base", io_base, 32'hFE24_0000);
        rd("R2 header word0", 10'h000, {DID, VID});
        rd("R2 header word1", 10'h004, 32'h0290_0080);
        rd("R2 header word2", 10'h008, 32'h0);
        rd("R3 caddr reset", 10'h1C0, 32'h0);
        rd("R4 mbase reset", 10'h1C4, 32'h0);
        rd("R5 iobase reset", 10'h1C8, 32'hFE24_0000);
        check("R11 local latency", cycles, 1);

        // R1 header window
        wr(10'h014, 32'h1122_3344);
        wr(10'h0FC, 32'hA5C3_0F96);
        rd("R1 header word5", 10'h014, 32'h1122_3344);
        rd("R1 header last", 10'h0FC, 32'hA5C3_0F96);

        // R3 / R4
        wr(10'h1C0, 32'hDEAD_BEEF);
        rd("R3 caddr full", 10'h1C0, 32'hDEAD_BEEF);
        wr(10'h1C4, 32'hFFFF_FFFF);
        rd("R4 mbase mask", 10'h1C4, 32'hFF00_0001);

        // R5 / R6
        wr(10'h1C8, 32'h1234_5677);
        @(negedge clk);
        check("R6 moved pulse count", moved_cnt, 1);
        check("R5 io_base port", io_base, 32'h1234_0001);
        rd("R5 iobase masked", 10'h1C8, 32'h1234_0001);
        wr(10'h1C8, 32'h1237_0000);
        @(negedge clk);
        check("R6 no pulse same window", moved_cnt, 1);
        rd("R5 iobase kept", 10'h1C8, 32'h1234_0001);
        wr(10'h1C8, 32'hFE24_0000);
        @(negedge clk);
        check("R6 pulse on move back", moved_cnt, 2);
        check("R5 io_base back", io_base, 32'hFE24_0000);

        // R7 data port write
        wr(10'h1C0, 32'h8000_1810);
        wr(10'h220, 32'hCAFE_F00D);
        check("R7 cfg count", cfg_cnt, 1);
        check("R7 cfg we", {31'h0, last_we}, 32'h1);
        check("R7 cfg addr", last_addr, 32'h8000_1810);
        check("R7 cfg data", last_data, 32'hCAFE_F00D);
        checks++;
        if (cycles <= ACK_DELAY + 1) begin
            errors++;
            $display("FAIL R7 ready held: actual=%0d expected>%0d", cycles, ACK_DELAY + 1);
        end

        // R8 data port read
        rd("R8 dport read", 10'h220, 32'h8000_1810 ^ 32'h5A5A_0000);
        check("R8 cfg we", {31'h0, last_we}, 32'h0);

        // R9 ignored accesses
        wr(10'h100, 32'hFFFF_FFFF);
        rd("R9 unused 0x100", 10'h100, 32'h0);
        rd("R9 unused 0x1CC", 10'h1CC, 32'h0);
        rd("R9 beyond 0x224", 10'h224, 32'h0);
        access(1, 10'h014, 32'h0, 4'h3);
        rd("R9 partial write ignored", 10'h014, 32'h1122_3344);
        exp_q.push_back(32'h0); tag_q.push_back("R9 partial read zero");
        access(0, 10'h014, 32'h0, 4'h1);
        access(1, 10'h220, 32'h1, 4'h7);
        check("R9 partial dport no cycle", cfg_cnt, 2);
        check("R11 partial dport latency", cycles, 1);
        access(1, 10'h1C6, 32'h0, 4'hF);
        rd("R9 unaligned write ignored", 10'h1C4, 32'hFF00_0001);

        // R10 interrupt routing
        @(negedge clk); irq_devfn = 8'h08; irq_assert = 1; #1;
        check("R10 slot1", {28'h0, irq_lines}, 32'h2);
        @(negedge clk); irq_devfn = 8'h1F; #1;
        check("R10 slot3", {28'h0, irq_lines}, 32'h8);
        @(negedge clk); irq_devfn = 8'h20; #1;
        check("R10 slot4 none", {28'h0, irq_lines}, 32'h0);
        @(negedge clk); irq_devfn = 8'h00; irq_assert = 0; #1;
        check("R10 deasserted", {28'h0, irq_lines}, 32'h0);

        repeat (2) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        summary();
    end
endmodule